// File: doc/BRIEF.md
# MMU Access Check and Fault Reporter

This block sits between a core's load, store and instruction-fetch path and an external TLB lookup port. Every access presents an address, an access kind (load, store or fetch), an access size and the current privilege level. The block settles each access as one of three outcomes:

- an identity mapping that skips the TLB,
- a translation whose result is checked against the permissions the TLB returns,
- a fault with a cause code.

The TLB array itself, page-table walking and replacement are outside this block. The TLB appears here only as a lookup. The block drives the virtual page number, and the TLB answers with hit, physical page, and read, write and execute permission bits.

The outcome is registered and appears one cycle after the request. A fault also updates three fault-reporting registers on that same clock edge:

- a bad-address register,
- a TLB-status register holding a data-access flag,
- a page-table-entry pointer.

The pointer has a base field that is kept and a virtual-page-number field that is overwritten. A probe request returns the pass/fail result and cause but leaves all three registers untouched. A build-time parameter removes the translation entirely, so that every aligned access maps to itself.

Top module: `mmu_access_checker`

## Requirements
- R1: When built with MMU_PRESENT=0, every aligned access responds ok with rsp_paddr equal to req_addr, whatever the privilege or TLB inputs.
- R2: A supervisor access (req_super=1) at or above 0xC0000000 ignores the TLB inputs, responds ok, and returns rsp_paddr equal to req_addr.
- R3: With the MMU present, an aligned user access (req_super=0) at or above 0x80000000 faults with cause 2 (supervisor-address) and loads badaddr with the address. It leaves pteaddr and tlbmisc_d unchanged.
- R4: On a TLB hit whose permission bit for the access kind is set, the response is ok and rsp_paddr = {tlb_ppn, req_addr[11:0]}. A response never has rsp_ok and rsp_fault both set.
- R5: A TLB hit without the needed permission faults. The cause is 4 for a load lacking read, 5 for a store lacking write, and 6 for a fetch lacking execute. Encodings are req_type 0 = load, 1 = store, 2 = fetch, 3 = load. The permission inputs are tlb_perm_r, tlb_perm_w and tlb_perm_x.
- R6: An access that needs translation and misses in the TLB faults with cause 3.
- R7: On a translation fault (cause 3 to 6), tlbmisc_d becomes 1 for a load or store and 0 for a fetch.
- R8: On a translation fault, badaddr takes the address. pteaddr bits [31:22] keep their value, pteaddr bits [21:2] take req_addr[31:12], and pteaddr bits [1:0] are 0.
- R9: A misaligned access faults with cause 1 ahead of every other rule and loads badaddr. A half-word access (req_size 1) is misaligned if addr[0] is set. A word access (req_size 2 or 3) is misaligned if addr[1:0] is not zero. Byte accesses (req_size 0) are never misaligned. pteaddr and tlbmisc_d are unchanged.
- R10: With req_probe=1, ok, fault and cause are reported as usual, but badaddr, pteaddr and tlbmisc_d do not change.
- R11: rsp_valid, rsp_ok, rsp_fault, rsp_cause and rsp_paddr appear one cycle after req_valid. The registers update on the same edge. In a cycle without req_valid, rsp_valid is 0 the next cycle and no register changes. On a fault rsp_paddr is 0.
- R12: After reset, rsp_valid, rsp_ok, rsp_fault, badaddr and tlbmisc_d are 0, and pteaddr is {PTBASE_RESET, 22'b0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_addr | input | 32 | Virtual address of the access |
| req_type | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| req_size | input | 2 | 0 byte, 1 half-word, 2 or 3 word |
| req_super | input | 1 | 1 for supervisor privilege |
| req_probe | input | 1 | Report only, no register update |
| tlb_vpn | output | 20 | Virtual page number presented to the TLB |
| tlb_hit | input | 1 | TLB found the page |
| tlb_ppn | input | 20 | Physical page number from the TLB |
| tlb_perm_r | input | 1 | Page readable |
| tlb_perm_w | input | 1 | Page writable |
| tlb_perm_x | input | 1 | Page executable |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | Access may complete |
| rsp_fault | output | 1 | Access faulted |
| rsp_cause | output | 3 | 0 none, 1 unaligned, 2 supervisor-address, 3 TLB miss, 4 read, 5 write, 6 execute |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| badaddr | output | 32 | Last faulting address |
| pteaddr | output | 32 | Page-table-entry pointer: base in [31:22], page number in [21:2] |
| tlbmisc_d | output | 1 | Last translation fault was a data access |

## Verification
The bench builds two instances on the same stimulus. The first has MMU_PRESENT=1 and a non-zero PTBASE_RESET (10'h2A5), so that a base field lost on a translation fault shows up in pteaddr. The second has MMU_PRESENT=0, which brings the identity-only variant and its unaligned check within reach. The default region limits put both boundaries, 0x7FFFFFFF/0x80000000 and 0xBFFFFFFC/0xC0000000, under test, together with unaligned accesses that would also trip the region rule.

// File: rtl/mmu_chk_pkg.sv
package mmu_chk_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  typedef enum logic [2:0] {
    CAUSE_NONE       = 3'd0,
    CAUSE_UNALIGN    = 3'd1,
    CAUSE_SUPER_ADDR = 3'd2,
    CAUSE_TLB_MISS   = 3'd3,
    CAUSE_PERM_R     = 3'd4,
    CAUSE_PERM_W     = 3'd5,
    CAUSE_PERM_X     = 3'd6
  } cause_e;

  localparam int unsigned CAUSE_W = 3;

  // Alignment rule: byte never, half needs bit 0 clear, word needs bits 1:0 clear
  function automatic logic misaligned(input logic [1:0] lo, input logic [1:0] sz);
    case (sz)
      2'd0:    misaligned = 1'b0;
      2'd1:    misaligned = lo[0];
      default: misaligned = |lo;
    endcase
  endfunction

  function automatic logic is_data_access(input logic [1:0] acc);
    is_data_access = (acc != ACC_FETCH);
  endfunction

endpackage

// File: rtl/mmu_region_decode.sv
module mmu_region_decode
  import mmu_chk_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter bit          MMU_PRESENT  = 1'b1,
  parameter logic [ADDR_W-1:0] USER_LIMIT   = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] KBYPASS_BASE = 32'hC000_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              super_mode,
  output logic              evt_misaligned,
  output logic              evt_super_fault,
  output logic              evt_bypass,
  output logic              evt_xlate
);

  assign evt_misaligned = misaligned(addr[1:0], size);

  generate
    if (MMU_PRESENT) begin : g_mmu
      logic high_user;
      logic high_kernel;
      assign high_user       = (addr >= USER_LIMIT);
      assign high_kernel     = (addr >= KBYPASS_BASE);
      assign evt_super_fault = !evt_misaligned && !super_mode && high_user;
      assign evt_bypass      = !evt_misaligned && super_mode && high_kernel;
      assign evt_xlate       = !evt_misaligned && !evt_super_fault && !evt_bypass;
    end else begin : g_nommu
      assign evt_super_fault = 1'b0;
      assign evt_bypass      = !evt_misaligned;
      assign evt_xlate       = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/mmu_perm_check.sv
module mmu_perm_check
  import mmu_chk_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12,
  localparam int unsigned PPN_W    = ADDR_W - PAGE_BITS
) (
  input  logic [1:0]           acc,
  input  logic [PAGE_BITS-1:0] page_off,
  input  logic                 hit,
  input  logic [PPN_W-1:0]     ppn,
  input  logic                 perm_r,
  input  logic                 perm_w,
  input  logic                 perm_x,
  output logic                 perm_ok,
  output logic [CAUSE_W-1:0]   xlate_cause,
  output logic [ADDR_W-1:0]    xlate_pa
);

  function automatic logic [ADDR_W-1:0] compose_pa(input logic [PPN_W-1:0] pg,
                                                   input logic [PAGE_BITS-1:0] off);
    compose_pa = {pg, off};
  endfunction

  logic needed_bit;

  always_comb begin
    case (acc)
      ACC_STORE: needed_bit = perm_w;
      ACC_FETCH: needed_bit = perm_x;
      default:   needed_bit = perm_r;
    endcase
  end

  assign perm_ok  = hit && needed_bit;
  assign xlate_pa = compose_pa(ppn, page_off);

  always_comb begin
    if (!hit)            xlate_cause = CAUSE_TLB_MISS;
    else if (needed_bit) xlate_cause = CAUSE_NONE;
    else begin
      case (acc)
        ACC_STORE: xlate_cause = CAUSE_PERM_W;
        ACC_FETCH: xlate_cause = CAUSE_PERM_X;
        default:   xlate_cause = CAUSE_PERM_R;
      endcase
    end
  end

endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs
  import mmu_chk_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_BITS  = 12,
  parameter int unsigned ENTRY_BITS = 2,
  localparam int unsigned PPN_W     = ADDR_W - PAGE_BITS,
  localparam int unsigned BASE_W    = ADDR_W - PPN_W - ENTRY_BITS,
  parameter logic [BASE_W-1:0] PTBASE_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_bad,
  input  logic              upd_xlate,
  input  logic [1:0]        acc,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] badaddr,
  output logic [ADDR_W-1:0] pteaddr,
  output logic              tlbmisc_d
);

  // Keep the base field, drop in the faulting page number above the entry bits
  function automatic logic [ADDR_W-1:0] next_pte(input logic [ADDR_W-1:0] cur,
                                                 input logic [ADDR_W-1:0] va);
    next_pte = {cur[ADDR_W-1 -: BASE_W], va[ADDR_W-1:PAGE_BITS], {ENTRY_BITS{1'b0}}};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      badaddr   <= '0;
      pteaddr   <= {PTBASE_RESET, {(ADDR_W-BASE_W){1'b0}}};
      tlbmisc_d <= 1'b0;
    end else begin
      if (upd_bad) badaddr <= addr;
      if (upd_xlate) begin
        pteaddr   <= next_pte(pteaddr, addr);
        tlbmisc_d <= is_data_access(acc);
      end
    end
  end

endmodule

// File: rtl/mmu_access_checker.sv
module mmu_access_checker
  import mmu_chk_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_BITS  = 12,
  parameter int unsigned ENTRY_BITS = 2,
  parameter bit          MMU_PRESENT = 1'b1,
  parameter logic [ADDR_W-1:0] USER_LIMIT   = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] KBYPASS_BASE = 32'hC000_0000,
  localparam int unsigned PPN_W  = ADDR_W - PAGE_BITS,
  localparam int unsigned BASE_W = ADDR_W - PPN_W - ENTRY_BITS,
  parameter logic [BASE_W-1:0] PTBASE_RESET = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_type,
  input  logic [1:0]         req_size,
  input  logic               req_super,
  input  logic               req_probe,
  output logic [PPN_W-1:0]   tlb_vpn,
  input  logic               tlb_hit,
  input  logic [PPN_W-1:0]   tlb_ppn,
  input  logic               tlb_perm_r,
  input  logic               tlb_perm_w,
  input  logic               tlb_perm_x,
  output logic               rsp_valid,
  output logic               rsp_ok,
  output logic               rsp_fault,
  output logic [CAUSE_W-1:0] rsp_cause,
  output logic [ADDR_W-1:0]  rsp_paddr,
  output logic [ADDR_W-1:0]  badaddr,
  output logic [ADDR_W-1:0]  pteaddr,
  output logic               tlbmisc_d
);

  logic               evt_misaligned;
  logic               evt_super_fault;
  logic               evt_bypass;
  logic               evt_xlate;
  logic               perm_ok;
  logic [CAUSE_W-1:0] xlate_cause;
  logic [ADDR_W-1:0]  xlate_pa;
  logic               evt_xlate_fault;
  logic               evt_any_fault;
  logic               acc_ok;
  logic [CAUSE_W-1:0] cause_next;
  logic [ADDR_W-1:0]  pa_next;
  logic               upd_bad;
  logic               upd_xlate;

  assign tlb_vpn = req_addr[ADDR_W-1:PAGE_BITS];

  mmu_region_decode #(
    .ADDR_W(ADDR_W), .MMU_PRESENT(MMU_PRESENT),
    .USER_LIMIT(USER_LIMIT), .KBYPASS_BASE(KBYPASS_BASE)
  ) u_region (
    .addr(req_addr), .size(req_size), .super_mode(req_super),
    .evt_misaligned(evt_misaligned), .evt_super_fault(evt_super_fault),
    .evt_bypass(evt_bypass), .evt_xlate(evt_xlate)
  );

  mmu_perm_check #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_perm (
    .acc(req_type), .page_off(req_addr[PAGE_BITS-1:0]), .hit(tlb_hit),
    .ppn(tlb_ppn), .perm_r(tlb_perm_r), .perm_w(tlb_perm_w), .perm_x(tlb_perm_x),
    .perm_ok(perm_ok), .xlate_cause(xlate_cause), .xlate_pa(xlate_pa)
  );

  assign evt_xlate_fault = evt_xlate && !perm_ok;
  assign evt_any_fault   = evt_misaligned || evt_super_fault || evt_xlate_fault;
  assign acc_ok          = evt_bypass || (evt_xlate && perm_ok);

  always_comb begin
    if (evt_misaligned)       cause_next = CAUSE_UNALIGN;
    else if (evt_super_fault) cause_next = CAUSE_SUPER_ADDR;
    else if (evt_xlate_fault) cause_next = xlate_cause;
    else                      cause_next = CAUSE_NONE;
  end

  always_comb begin
    if (evt_bypass)  pa_next = req_addr;
    else if (acc_ok) pa_next = xlate_pa;
    else             pa_next = '0;
  end

  assign upd_bad   = req_valid && !req_probe && evt_any_fault;
  assign upd_xlate = req_valid && !req_probe && evt_xlate_fault;

  mmu_fault_regs #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ENTRY_BITS(ENTRY_BITS),
    .PTBASE_RESET(PTBASE_RESET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .upd_bad(upd_bad), .upd_xlate(upd_xlate),
    .acc(req_type), .addr(req_addr),
    .badaddr(badaddr), .pteaddr(pteaddr), .tlbmisc_d(tlbmisc_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= CAUSE_NONE;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_ok    <= req_valid && acc_ok;
      rsp_fault <= req_valid && evt_any_fault;
      rsp_cause <= req_valid ? cause_next : CAUSE_NONE;
      rsp_paddr <= req_valid ? pa_next : '0;
    end
  end

endmodule

// File: rtl/mmu_access_checker_sva.sv
module mmu_access_checker_sva #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_BITS  = 12,
  parameter int unsigned ENTRY_BITS = 2,
  parameter bit          MMU_PRESENT = 1'b1,
  parameter logic [ADDR_W-1:0] USER_LIMIT   = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] KBYPASS_BASE = 32'hC000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_probe,
  input logic              req_super,
  input logic [1:0]        req_type,
  input logic [ADDR_W-1:0] req_addr,
  input logic              evt_misaligned,
  input logic              evt_xlate_fault,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic              rsp_fault,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [ADDR_W-1:0] badaddr,
  input logic [ADDR_W-1:0] pteaddr,
  input logic              tlbmisc_d
);

  localparam int unsigned VPN_HI = ADDR_W - PAGE_BITS + ENTRY_BITS - 1;

  a_r11_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(badaddr) && $stable(pteaddr) && $stable(tlbmisc_d)));

  a_r10_probe_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_probe) |=> ($stable(badaddr) && $stable(pteaddr) && $stable(tlbmisc_d)));

  a_r3_user_high_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (MMU_PRESENT && req_valid && !req_super && req_addr >= USER_LIMIT && !evt_misaligned)
      |=> (rsp_fault && $stable(pteaddr)));

  a_r2_super_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_super && req_addr >= KBYPASS_BASE && !evt_misaligned)
      |=> (rsp_ok && rsp_paddr == $past(req_addr)));

  a_r8_vpn_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_probe && evt_xlate_fault)
      |=> (pteaddr[VPN_HI:ENTRY_BITS] == $past(req_addr[ADDR_W-1:PAGE_BITS])
           && badaddr == $past(req_addr)));

  a_r7_data_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_probe && evt_xlate_fault) |=> (tlbmisc_d == ($past(req_type) != 2'd2)));

  a_r9_unaligned_no_pte: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && evt_misaligned) |=> (rsp_fault && $stable(pteaddr)));

  a_r4_ok_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_ok, rsp_fault}));

endmodule

bind mmu_access_checker mmu_access_checker_sva #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ENTRY_BITS(ENTRY_BITS),
  .MMU_PRESENT(MMU_PRESENT), .USER_LIMIT(USER_LIMIT), .KBYPASS_BASE(KBYPASS_BASE)
) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_probe(req_probe),
  .req_super(req_super), .req_type(req_type), .req_addr(req_addr),
  .evt_misaligned(evt_misaligned), .evt_xlate_fault(evt_xlate_fault),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr), .badaddr(badaddr), .pteaddr(pteaddr), .tlbmisc_d(tlbmisc_d)
);

// File: tb/mmu_access_checker_tb.sv
module mmu_access_checker_tb;

  localparam logic [9:0] PTB = 10'h2A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_type = '0;
  logic [1:0]  req_size = '0;
  logic        req_super = 1'b0;
  logic        req_probe = 1'b0;
  logic        tlb_hit = 1'b0;
  logic [19:0] tlb_ppn = '0;
  logic        tlb_perm_r = 1'b0, tlb_perm_w = 1'b0, tlb_perm_x = 1'b0;

  logic [19:0] tlb_vpn, n_vpn;
  logic        rsp_valid, rsp_ok, rsp_fault, tlbmisc_d;
  logic [2:0]  rsp_cause;
  logic [31:0] rsp_paddr, badaddr, pteaddr;
  logic        n_valid, n_ok, n_fault, n_d;
  logic [2:0]  n_cause;
  logic [31:0] n_paddr, n_bad, n_pte;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mmu_access_checker #(.MMU_PRESENT(1'b1), .PTBASE_RESET(PTB)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_type(req_type), .req_size(req_size), .req_super(req_super), .req_probe(req_probe),
    .tlb_vpn(tlb_vpn), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .tlb_perm_r(tlb_perm_r), .tlb_perm_w(tlb_perm_w), .tlb_perm_x(tlb_perm_x),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_paddr(rsp_paddr), .badaddr(badaddr), .pteaddr(pteaddr), .tlbmisc_d(tlbmisc_d)
  );

  mmu_access_checker #(.MMU_PRESENT(1'b0), .PTBASE_RESET(PTB)) u_nommu (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_type(req_type), .req_size(req_size), .req_super(req_super), .req_probe(req_probe),
    .tlb_vpn(n_vpn), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .tlb_perm_r(tlb_perm_r), .tlb_perm_w(tlb_perm_w), .tlb_perm_x(tlb_perm_x),
    .rsp_valid(n_valid), .rsp_ok(n_ok), .rsp_fault(n_fault), .rsp_cause(n_cause),
    .rsp_paddr(n_paddr), .badaddr(n_bad), .pteaddr(n_pte), .tlbmisc_d(n_d)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  acc;    // 0 load, 1 store, 2 fetch
    logic [1:0]  sz;     // 0 byte, 1 half, 2 word
    logic        sup;
    logic        probe;
    logic        hit;
    logic [19:0] ppn;
    logic [2:0]  rwx;    // bit2 read, bit1 write, bit0 execute
    logic [2:0]  cause;  // expected cause
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'h0040_1234, 2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 20'h12345, 3'b100, 3'd0}, // R4 load ok
    '{32'h0040_2008, 2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 20'h00111, 3'b100, 3'd5}, // R5 store no write
    '{32'h0001_0000, 2'd2, 2'd2, 1'b0, 1'b0, 1'b1, 20'h00222, 3'b110, 3'd6}, // R5 fetch no exec
    '{32'h1000_0000, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 20'h00333, 3'b010, 3'd4}, // R5 load no read
    '{32'h0000_3000, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 20'h00000, 3'b111, 3'd3}, // R6 load miss
    '{32'h0000_5000, 2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 20'h00000, 3'b111, 3'd3}, // R6 R7 fetch miss
    '{32'h8000_0000, 2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 20'h00444, 3'b111, 3'd2}, // R3 lowest high
    '{32'hFFFF_FFFC, 2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 20'h00444, 3'b111, 3'd2}, // R3 top
    '{32'hC000_0010, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 20'h00000, 3'b000, 3'd0}, // R2 bypass
    '{32'hBFFF_FFFC, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 20'h00000, 3'b000, 3'd3}, // R6 below bypass
    '{32'h8000_1000, 2'd2, 2'd2, 1'b1, 1'b0, 1'b1, 20'h00ABC, 3'b001, 3'd0}, // R4 super fetch
    '{32'h7FFF_F001, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 20'h00555, 3'b111, 3'd1}, // R9 half odd
    '{32'h8000_0002, 2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 20'h00555, 3'b111, 3'd1}, // R9 over R3
    '{32'h0040_0003, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 20'h00001, 3'b100, 3'd0}, // R9 byte fine
    '{32'h0077_7000, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 20'h00000, 3'b000, 3'd3}, // R10 probe miss
    '{32'h7FFF_FFFC, 2'd3, 2'd3, 1'b0, 1'b0, 1'b1, 20'h00666, 3'b011, 3'd4}  // R5 type 3 as load
  };

  logic [31:0] m_bad;
  logic [31:0] m_pte;
  logic        m_d;

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.probe) return "R10";
    case (v.cause)
      3'd0: return (v.sup && v.addr >= 32'hC000_0000) ? "R2" : "R4";
      3'd1: return "R9";
      3'd2: return "R3";
      3'd3: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic apply(input vec_t v);
    logic [31:0] exp_pa;
    logic        misal;
    @(negedge clk);
    req_addr = v.addr; req_type = v.acc; req_size = v.sz; req_super = v.sup;
    req_probe = v.probe; tlb_hit = v.hit; tlb_ppn = v.ppn;
    tlb_perm_r = v.rwx[2]; tlb_perm_w = v.rwx[1]; tlb_perm_x = v.rwx[0];
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (v.cause != 3'd0) exp_pa = 32'h0;
    else if (v.sup && v.addr >= 32'hC000_0000) exp_pa = v.addr;
    else exp_pa = (32'(v.ppn) << 12) | (v.addr & 32'h0000_0FFF);
    check("R11", "rsp_valid", 32'(rsp_valid), 32'h1);
    check(tag_of(v), "rsp_cause", 32'(rsp_cause), 32'(v.cause));
    check(tag_of(v), "rsp_ok", 32'(rsp_ok), 32'(v.cause == 3'd0));
    check(tag_of(v), "rsp_fault", 32'(rsp_fault), 32'(v.cause != 3'd0));
    check(tag_of(v), "rsp_paddr", rsp_paddr, exp_pa);
    if (!v.probe && v.cause != 3'd0) m_bad = v.addr;
    if (!v.probe && v.cause >= 3'd3) begin
      m_pte = (32'(PTB) << 22) | ((v.addr >> 10) & 32'h003F_FFFC);
      m_d   = (v.acc != 2'd2);
    end
    check(v.probe ? "R10" : "R8", "badaddr", badaddr, m_bad);
    check(v.probe ? "R10" : "R8", "pteaddr", pteaddr, m_pte);
    check(v.probe ? "R10" : "R7", "tlbmisc_d", 32'(tlbmisc_d), 32'(m_d));
    // R1: identity-only instance
    misal = (v.sz == 2'd1) ? v.addr[0] : (v.sz == 2'd0) ? 1'b0 : (v.addr[1:0] != 2'b00);
    check(misal ? "R9" : "R1", "nommu ok", 32'(n_ok), 32'(!misal));
    check(misal ? "R9" : "R1", "nommu cause", 32'(n_cause), misal ? 32'd1 : 32'd0);
    check(misal ? "R9" : "R1", "nommu paddr", n_paddr, misal ? 32'h0 : v.addr);
  endtask

  initial begin
    #800_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_bad = 32'h0;
    m_pte = {PTB, 22'h0};
    m_d   = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "rsp_valid", 32'(rsp_valid), 32'h0);
    check("R12", "rsp_ok", 32'(rsp_ok), 32'h0);
    check("R12", "rsp_fault", 32'(rsp_fault), 32'h0);
    check("R12", "badaddr", badaddr, 32'h0);
    check("R12", "pteaddr", pteaddr, m_pte);
    check("R12", "tlbmisc_d", 32'(tlbmisc_d), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) apply(VECS[i]);

    // R11: faulting inputs without req_valid change nothing
    @(negedge clk);
    req_addr = 32'h0000_9000; req_type = 2'd1; req_size = 2'd2; req_super = 1'b0;
    req_probe = 1'b0; tlb_hit = 1'b0;
    @(negedge clk);
    check("R11", "idle rsp_valid", 32'(rsp_valid), 32'h0);
    check("R11", "idle rsp_fault", 32'(rsp_fault), 32'h0);
    check("R11", "idle badaddr", badaddr, m_bad);
    check("R11", "idle pteaddr", pteaddr, m_pte);
    check("R11", "idle tlbmisc_d", 32'(tlbmisc_d), 32'(m_d));

    // R3: supervisor-address fault keeps pteaddr and data flag from the fetch fault
    apply('{32'h0000_6000, 2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 20'h0, 3'b000, 3'd3});
    apply('{32'h9000_0000, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 20'h0, 3'b000, 3'd2});
    check("R3", "tlbmisc_d kept", 32'(tlbmisc_d), 32'h0);

    // R12: reset again mid-run restores base pointer
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R12", "pteaddr after reset", pteaddr, {PTB, 22'h0});
    check("R12", "badaddr after reset", badaddr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule